// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block controls one switchable power domain. Software owns a single 32-bit control/status word on a plain write-strobe register bus. Clearing the collapse bit asks for power; setting it asks for collapse. A state machine then drives the domain's power switches, isolation clamp, domain reset and clock enable in a fixed order. Each step is held for a programmable wait of 2^n reference-clock cycles.

Power-up turns on a small first group of head switches, then the remaining switches, then lifts the clamp and the reset together, and finally enables the clock. The clock follows a fixed lag after the clamp is lifted. A power-good flag is raised only once the whole sequence has finished. Power-down runs the same steps in reverse. A request that arrives mid-sequence is held in the register and acted on once the machine reaches a settled on or off state. The hardware-trigger select and software-override bits are stored and read back but do not alter the sequencing.

Top module: `pd_gate_seq`

## Requirements
- R1: After reset the domain is collapsed (switch enables 0, clamp 1, domain reset 1, clock enable 0, power-good 0) and the register reads 0x00222001: collapse bit 0 set, and the three wait exponents at bits 23:20 (remaining switches), 19:16 (first switches) and 15:12 (clock off) all equal 2.
- R2: Bits 0, 1, 2 and the three 4-bit wait fields are read/write. Bit 31 and bits 30:24 and 11:3 ignore writes; the unused bits read 0.
- R3: While the domain is collapsed, writing bit 0 = 0 turns on the first switch group one cycle after the write edge.
- R4: The remaining switches turn on 2^n cycles after the first group, where n is bits 19:16.
- R5: Clamp and domain reset are released together 2^n cycles after the remaining switches turn on, where n is bits 23:20.
- R6: The clock enable rises 4 cycles after the clamp is released. Power-good (output and bit 31) rises in that same cycle and is never 1 while the clock is disabled.
- R7: While the domain is on, writing bit 0 = 1 drops the clock enable and power-good one cycle after the write edge.
- R8: Clamp and domain reset are asserted together 2^n cycles after the clock drops, where n is bits 15:12. Both switch groups turn off one cycle later.
- R9: A request written while a sequence runs does not interrupt it. The sequence completes, and the opposite sequence starts one cycle after the settled state is reached.
- R10: Bits 1 and 2 have no effect on output timing or levels.
- R11: The remaining switches are never on without the first group. The clamp is never released unless both groups are on. The clock is never enabled while the clamp or reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data (combinational) |
| sw_few_en | output | 1 | Enable for the first head-switch group |
| sw_rest_en | output | 1 | Enable for the remaining head switches |
| iso_clamp | output | 1 | Isolation clamp, 1 = clamped |
| dom_rst | output | 1 | Domain reset, 1 = held in reset |
| dom_clk_en | output | 1 | Domain clock enable |
| pwr_good | output | 1 | Domain fully powered |

## Verification
The assertions assume that reset is held low for at least one clock edge and that the write strobe and data carry no unknown values once reset is released. Their past-value checks rely on the synchronous reset having settled every output to the collapsed state. The stimulus keeps every write to a single strobed cycle with stable data, driven between clock edges. It programs only small wait exponents (0 to 3), so each sequence stays short. Mid-sequence writes are timed to land inside a known wait step, so that the deferred reaction has a single expected cycle.

// File: rtl/pd_gate_pkg.sv
// Shared constants and state type for the power domain gating sequencer.
// Assumes the register layout below is fixed by software that decodes it.
package pd_gate_pkg;
    localparam int EXP_W        = 4;   // width of one wait exponent field
    localparam int NUM_WAIT     = 3;   // number of programmable waits
    localparam int WAIT_BASE    = 12;  // lsb of the lowest wait field
    localparam int WI_CLKOFF    = 0;   // field index: clock-off wait (15:12)
    localparam int WI_FEW       = 1;   // field index: first-switch wait (19:16)
    localparam int WI_REST      = 2;   // field index: remaining-switch wait (23:20)
    localparam int BIT_COLLAPSE = 0;
    localparam int BIT_HWTRIG   = 1;
    localparam int BIT_OVR      = 2;
    localparam int BIT_PWRON    = 31;
    localparam logic [EXP_W-1:0] WAIT_RST = 4'd2;

    typedef enum logic [2:0] {
        PD_OFF,      // collapsed, clamped, in reset
        PD_FEW,      // first switch group on
        PD_REST,     // all switches on
        PD_UNCLAMP,  // clamp and reset lifted, clock still off
        PD_ON,       // clock on, power good
        PD_CLKOFF,   // clock stopped, still unclamped
        PD_CLAMP     // clamp and reset asserted, switches still on
    } pd_state_e;
endpackage

// File: rtl/pd_csr.sv
// Control/status word for the sequencer.
// Holds the collapse request, two stored-only mode bits and the wait
// exponents; reports the power-good flag at its fixed position.
// Assumes csr_wr is a single-cycle strobe in the clk domain.
module pd_csr
    import pd_gate_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              csr_wr,
    input  logic [31:0]                       csr_wdata,
    input  logic                              pwr_on,
    output logic [31:0]                       csr_rdata,
    output logic                              collapse,
    output logic [NUM_WAIT-1:0][EXP_W-1:0]    wait_exp
);
    logic hw_trig_q;
    logic sw_ovr_q;

    // Collapse request and mode bits: captured on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collapse  <= 1'b1;
            hw_trig_q <= 1'b0;
            sw_ovr_q  <= 1'b0;
        end else if (csr_wr) begin
            collapse  <= csr_wdata[BIT_COLLAPSE];
            hw_trig_q <= csr_wdata[BIT_HWTRIG];
            sw_ovr_q  <= csr_wdata[BIT_OVR];
        end
    end

    // One register per wait exponent field, laid out from WAIT_BASE upward
    for (genvar gi = 0; gi < NUM_WAIT; gi++) begin : g_wait
        localparam int LSB = WAIT_BASE + gi * EXP_W;
        always_ff @(posedge clk) begin
            if (!rst_n)
                wait_exp[gi] <= WAIT_RST;
            else if (csr_wr)
                wait_exp[gi] <= csr_wdata[LSB +: EXP_W];
        end
    end

    // Read view: stored fields plus live power-good, zeros elsewhere
    always_comb begin
        csr_rdata               = '0;
        csr_rdata[BIT_COLLAPSE] = collapse;
        csr_rdata[BIT_HWTRIG]   = hw_trig_q;
        csr_rdata[BIT_OVR]      = sw_ovr_q;
        for (int i = 0; i < NUM_WAIT; i++)
            csr_rdata[WAIT_BASE + i*EXP_W +: EXP_W] = wait_exp[i];
        csr_rdata[BIT_PWRON]    = pwr_on;
    end

    AST_WAIT_KEPT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr |=> $stable(wait_exp)) else $error("wait field changed without write"); // R2
endmodule

// File: rtl/pd_wait_timer.sv
// Down-counter giving a wait of 2^n cycles.
// A load pulse with exponent n arms the counter at 2^n - 1; done is high
// while the count is zero, so a state that leaves on done lasts 2^n cycles.
// Assumes n < 2^EXP_W so that 2^n fits the counter.
module pd_wait_timer #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [EXP_W-1:0] load_exp,
    output logic             done
);
    localparam int CNT_W = 1 << EXP_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    // Span of the requested wait as a single set bit
    always_comb span = {{(CNT_W-1){1'b0}}, 1'b1} << load_exp;

    // Count down from span-1 to zero, then hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= span - {{(CNT_W-1){1'b0}}, 1'b1};
        else if (cnt != '0)
            cnt <= cnt - {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_comb done = (cnt == '0);

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done) else $error("timer left zero without load"); // R4
endmodule

// File: rtl/pd_seq_fsm.sv
// Sequencing state machine for one power domain.
// Moves between the settled OFF and ON states only; a changed request is
// seen only in those states, so a running sequence always completes.
// Outputs are decoded from the state register, one step per state.
// Assumes the wait timer reports done for the wait loaded on entry.
module pd_seq_fsm
    import pd_gate_pkg::*;
#(
    parameter int LAG_EXP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             collapse,
    input  logic [EXP_W-1:0] exp_few,
    input  logic [EXP_W-1:0] exp_rest,
    input  logic [EXP_W-1:0] exp_clkoff,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [EXP_W-1:0] tmr_exp,
    output logic             sw_few_en,
    output logic             sw_rest_en,
    output logic             iso_clamp,
    output logic             dom_rst,
    output logic             dom_clk_en,
    output logic             pwr_good
);
    localparam logic [EXP_W-1:0] LAG = EXP_W'(LAG_EXP);

    pd_state_e state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_OFF;
        else        state <= state_nx;
    end

    // Next state and timer arming on each step boundary
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_exp  = '0;
        unique case (state)
            PD_OFF: if (!collapse) begin
                state_nx = PD_FEW;
                tmr_load = 1'b1;
                tmr_exp  = exp_few;
            end
            PD_FEW: if (tmr_done) begin
                state_nx = PD_REST;
                tmr_load = 1'b1;
                tmr_exp  = exp_rest;
            end
            PD_REST: if (tmr_done) begin
                state_nx = PD_UNCLAMP;
                tmr_load = 1'b1;
                tmr_exp  = LAG;
            end
            PD_UNCLAMP: if (tmr_done) state_nx = PD_ON;
            PD_ON: if (collapse) begin
                state_nx = PD_CLKOFF;
                tmr_load = 1'b1;
                tmr_exp  = exp_clkoff;
            end
            PD_CLKOFF: if (tmr_done) state_nx = PD_CLAMP;
            PD_CLAMP:  state_nx = PD_OFF;
            default:   state_nx = PD_OFF;
        endcase
    end

    // Output decode: which domain controls each state drives
    always_comb begin
        sw_few_en  = (state != PD_OFF);
        sw_rest_en = (state != PD_OFF) && (state != PD_FEW);
        iso_clamp  = (state == PD_OFF) || (state == PD_FEW) ||
                     (state == PD_REST) || (state == PD_CLAMP);
        dom_rst    = iso_clamp;
        dom_clk_en = (state == PD_ON);
        pwr_good   = (state == PD_ON);
    end

    AST_UP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_few_en) |-> !collapse) else $error("power-up without request"); // R3
    AST_SW_OFF_AFTER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_few_en) |-> ($past(iso_clamp) && !dom_clk_en)) else $error("switches dropped unclamped"); // R8
endmodule

// File: rtl/pd_gate_seq.sv
// Top of the power domain gating sequencer.
// Ties the control word, the sequencing state machine and the shared wait
// timer together. All logic runs on the reference clock with a synchronous
// active-low reset. LAG_EXP sets the clock re-enable lag as 2^LAG_EXP.
module pd_gate_seq
    import pd_gate_pkg::*;
#(
    parameter int LAG_EXP = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        sw_few_en,
    output logic        sw_rest_en,
    output logic        iso_clamp,
    output logic        dom_rst,
    output logic        dom_clk_en,
    output logic        pwr_good
);
    logic                           collapse;
    logic [NUM_WAIT-1:0][EXP_W-1:0] wait_exp;
    logic                           tmr_load;
    logic [EXP_W-1:0]               tmr_exp;
    logic                           tmr_done;

    pd_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .pwr_on    (pwr_good),
        .csr_rdata (csr_rdata),
        .collapse  (collapse),
        .wait_exp  (wait_exp)
    );

    pd_seq_fsm #(.LAG_EXP(LAG_EXP)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .collapse   (collapse),
        .exp_few    (wait_exp[WI_FEW]),
        .exp_rest   (wait_exp[WI_REST]),
        .exp_clkoff (wait_exp[WI_CLKOFF]),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_exp    (tmr_exp),
        .sw_few_en  (sw_few_en),
        .sw_rest_en (sw_rest_en),
        .iso_clamp  (iso_clamp),
        .dom_rst    (dom_rst),
        .dom_clk_en (dom_clk_en),
        .pwr_good   (pwr_good)
    );

    pd_wait_timer #(.EXP_W(EXP_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_exp (tmr_exp),
        .done     (tmr_done)
    );

    AST_REST_NEEDS_FEW: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rest_en |-> sw_few_en) else $error("remaining switches without first group"); // R11
    AST_UNCLAMP_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_clamp |-> (sw_few_en && sw_rest_en)) else $error("unclamped without switches"); // R11
    AST_CLK_NEEDS_UNCLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        dom_clk_en |-> (!iso_clamp && !dom_rst)) else $error("clock while clamped"); // R11
    AST_GOOD_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> dom_clk_en) else $error("power good without clock"); // R6
    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[BIT_PWRON] == pwr_good) else $error("status bit mismatch"); // R6
endmodule

// File: tb/sim_pd_gate_seq.sv
module sim_pd_gate_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        sw_few_en, sw_rest_en, iso_clamp, dom_rst, dom_clk_en, pwr_good;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t_wr   = 0;
    int inv_err = 0;
    bit finished = 1'b0;

    // edge stamps taken by the monitor
    int t_few_up, t_rest_up, t_unclamp, t_clk_up, t_pg_up;
    int t_clk_dn, t_pg_dn, t_clamp_up, t_rst_up, t_few_dn, t_rest_dn;
    logic p_few = 0, p_rest = 0, p_clamp = 1, p_rst = 1, p_clk = 0, p_pg = 0;

    always #4 clk = ~clk;  // 125 MHz

    pd_gate_seq u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en),
        .iso_clamp(iso_clamp), .dom_rst(dom_rst), .dom_clk_en(dom_clk_en),
        .pwr_good(pwr_good)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: stamp output edges and count ordering violations (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (sw_few_en && !p_few)   t_few_up   = cyc;
            if (!sw_few_en && p_few)   t_few_dn   = cyc;
            if (sw_rest_en && !p_rest) t_rest_up  = cyc;
            if (!sw_rest_en && p_rest) t_rest_dn  = cyc;
            if (!iso_clamp && p_clamp) t_unclamp  = cyc;
            if (iso_clamp && !p_clamp) t_clamp_up = cyc;
            if (dom_rst && !p_rst)     t_rst_up   = cyc;
            if (dom_clk_en && !p_clk)  t_clk_up   = cyc;
            if (!dom_clk_en && p_clk)  t_clk_dn   = cyc;
            if (pwr_good && !p_pg)     t_pg_up    = cyc;
            if (!pwr_good && p_pg)     t_pg_dn    = cyc;
            if (sw_rest_en && !sw_few_en) inv_err++;
            if (!iso_clamp && !(sw_few_en && sw_rest_en)) inv_err++;
            if (dom_clk_en && (iso_clamp || dom_rst)) inv_err++;
            if (pwr_good && !dom_clk_en) inv_err++;
            if (pwr_good != csr_rdata[31]) inv_err++;
        end
        p_few = sw_few_en; p_rest = sw_rest_en; p_clamp = iso_clamp;
        p_rst = dom_rst; p_clk = dom_clk_en; p_pg = pwr_good;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        t_wr = cyc;
    endtask

    task automatic wait_pg(input logic v);
        for (int i = 0; i < 2000 && pwr_good !== v; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_off();
        for (int i = 0; i < 2000 && sw_few_en !== 1'b0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int outs();
        return {26'd0, sw_few_en, sw_rest_en, iso_clamp, dom_rst, dom_clk_en, pwr_good};
    endfunction

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk("R1 rdata", csr_rdata, 32'h0022_2001);
        chk("R1 outputs", outs(), 6'b001100);
    endtask

    // R2/R10: register access, ignored bits, mode bits do not move outputs
    task automatic t_regs();
        csr_write(32'hFFFF_FFFF);
        chk("R2 all-ones readback", csr_rdata, 32'h00FF_F007);
        repeat (10) @(negedge clk);
        chk("R10 outputs unchanged with mode bits", outs(), 6'b001100);
        csr_write(32'h4FA5_B003);
        chk("R2 pattern readback", csr_rdata, 32'h00A5_B003);
        csr_write(32'h0022_2001);
        chk("R2 restore readback", csr_rdata, 32'h0022_2001);
    endtask

    // R3-R6: power-up with default waits
    task automatic t_up_default();
        csr_write(32'h0022_2000);
        wait_pg(1'b1);
        chk("R3 first switches delay", t_few_up - t_wr, 1);
        chk("R4 remaining switches delay", t_rest_up - t_few_up, 4);
        chk("R5 unclamp delay", t_unclamp - t_rest_up, 4);
        chk("R6 clock lag", t_clk_up - t_unclamp, 4);
        chk("R6 power good with clock", t_pg_up - t_clk_up, 0);
        chk("R6 status readback", csr_rdata, 32'h8022_2000);
        chk("R5 reset released", dom_rst, 0);
    endtask

    // R7-R8: power-down with default waits
    task automatic t_down_default();
        csr_write(32'h0022_2001);
        wait_off();
        chk("R7 clock off delay", t_clk_dn - t_wr, 1);
        chk("R7 power good drop", t_pg_dn - t_wr, 1);
        chk("R8 clamp delay", t_clamp_up - t_clk_dn, 4);
        chk("R8 reset with clamp", t_rst_up - t_clamp_up, 0);
        chk("R8 switches off", t_few_dn - t_clamp_up, 1);
        chk("R8 both groups off", t_rest_dn - t_few_dn, 0);
        chk("R8 readback", csr_rdata, 32'h0022_2001);
    endtask

    // R4/R5/R8/R10: other exponents, mode bits set
    task automatic t_other_exps();
        csr_write(32'h0031_0006);
        wait_pg(1'b1);
        chk("R3 first switches delay n", t_few_up - t_wr, 1);
        chk("R4 few wait 2^1", t_rest_up - t_few_up, 2);
        chk("R5 rest wait 2^3", t_unclamp - t_rest_up, 8);
        chk("R10 clock lag with mode bits", t_clk_up - t_unclamp, 4);
        csr_write(32'h0031_0007);
        wait_off();
        chk("R8 clock-off wait 2^0", t_clamp_up - t_clk_dn, 1);
        chk("R8 switches off n", t_few_dn - t_clamp_up, 1);
    endtask

    // R9: requests during running sequences are deferred
    task automatic t_latch();
        int w0;
        csr_write(32'h0012_3000);
        w0 = t_wr;
        repeat (2) @(negedge clk);
        csr_write(32'h0012_3001);
        chk("R9 power good low mid sequence", pwr_good, 0);
        wait_off();
        chk("R9 power-up completes", t_pg_up - w0, 11);
        chk("R9 down starts after on", t_pg_dn - t_pg_up, 1);
        chk("R9 clock-off wait 2^3", t_clamp_up - t_clk_dn, 8);
        csr_write(32'h0012_3000);
        w0 = t_wr;
        repeat (2) @(negedge clk);
        chk("R9 clock still off before re-up", dom_clk_en, 0);
        wait_pg(1'b1);
        csr_write(32'h0012_3001);
        repeat (2) @(negedge clk);
        csr_write(32'h0012_3000);
        wait_pg(1'b0);
        for (int i = 0; i < 200 && !(pwr_good && t_few_up > t_few_dn); i++) @(negedge clk);
        chk("R9 re-up one cycle after off", t_few_up - t_few_dn, 1);
        chk("R9 second cycle reaches on", pwr_good, 1);
        csr_write(32'h0012_3001);
        wait_off();
        chk("R11 ordering invariants", inv_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_up_default();
        t_down_default();
        t_other_exps();
        t_latch();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule